// File: doc/BRIEF.md
# Serial CRC Generator and Checker

This block divides a serial bit stream, modulo 2, by a fixed six-bit divisor (x^5 + x^4 + x^2 + 1, pattern 110101) and keeps the five-bit remainder. One datapath serves two uses. A sender feeds it a message and reads back the frame check sequence (FCS) that it then appends to the message. A receiver feeds it a whole frame, message followed by FCS, and learns whether that frame divides evenly.

Bits arrive most significant first, one per clock, when the valid input is high. A start marker given with the first valid bit clears the remainder and samples the mode. An end marker given with the last valid bit closes the frame. In generate mode the block then shifts in five zero bits on its own, which is the same as multiplying the message by 2^5, before it reports the result. In check mode it reports at once. A one-cycle done strobe marks the result. The verdict flag stays valid from that strobe until the next frame starts.

Top module: `crc_serial_unit`

## Requirements
- R1: While reset is high and in the first cycle after it, rem_o is 00000, done_o is 0 and ok_o is 0.
- R2: With mode_i = 1 at frame start (generate), the final rem_o is the remainder of (message times 2^5) divided by 110101. Message 1010001101 gives 01110.
- R3: With mode_i = 0 at frame start (check), the final rem_o is the remainder of the whole frame divided by 110101, and ok_o is 1 exactly when that remainder is 00000. Frame 101000110101110 gives 00000.
- R4: Data bits are taken MSB first, one per clock while bit_vld_i is 1. Cycles with bit_vld_i = 0 do not change rem_o, so gaps between bits do not change the result.
- R5: sof_i together with bit_vld_i starts a frame. The remainder restarts from zero with that bit, and mode_i is sampled only in that cycle. Later changes of mode_i within the frame have no effect.
- R6: In check mode, done_o is 1 in the cycle after the clock edge that takes the bit marked by eof_i. In generate mode, five zero-padding steps follow that edge, and done_o is 1 six cycles after it.
- R7: done_o is high for a single cycle for each frame longer than one bit.
- R8: ok_o takes its verdict in the done_o cycle and holds it until a new frame starts. It reads 0 in the cycle after a start is accepted.
- R9: Valid bits that arrive during zero padding, or outside any frame, do not change rem_o.
- R10: In generate mode, ok_o is 1 in the done_o cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| bit_vld_i | input | 1 | Qualifies bit_i, sof_i and eof_i |
| bit_i | input | 1 | Serial data bit, MSB first |
| sof_i | input | 1 | First bit of a frame |
| eof_i | input | 1 | Last bit of a frame |
| mode_i | input | 1 | 1 = generate FCS, 0 = check frame; sampled at start |
| rem_o | output | 5 | Remainder register (FCS in generate mode) |
| done_o | output | 1 | One-cycle result strobe |
| ok_o | output | 1 | Verdict: frame divides evenly (always 1 in generate mode) |

## Verification
The bench uses the default configuration: five-bit remainder, divisor 110101, and a padding counter that counts five steps. With these settings the worked message and frame can be checked bit for bit. A long-division model in the bench, independent of the design, gives the expected remainder of other messages, of frames built from their FCS, and of frames with single-bit and burst errors. The same settings also let the bench count the exact six-cycle and one-cycle done latencies, and bring within reach the gaps in valid, the changes of mode within a frame, and the stray bits sent during padding.

// File: rtl/crc_serial_pkg.sv
package crc_serial_pkg;

    localparam int unsigned CRC_W = 5;
    localparam logic [CRC_W:0] CRC_POLY = 6'b110101;
    localparam int unsigned PAD_CNT_W = $clog2(CRC_W + 1);

    typedef logic [CRC_W-1:0] rem_t;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_DATA,
        SQ_PAD
    } seq_state_e;

    typedef struct packed {
        logic clr;  // restart remainder from zero
        logic adv;  // perform one division step
        logic din;  // bit entering the division
        logic fin;  // this step is the last of the frame
        logic gen;  // frame is in generate mode
    } step_ctl_t;

    // One long-division step: shift in a bit, subtract divisor if the
    // bit leaving the top was set.
    function automatic rem_t div_step(input rem_t r, input logic b);
        rem_t sh;
        sh = {r[CRC_W-2:0], b};
        return r[CRC_W-1] ? (sh ^ CRC_POLY[CRC_W-1:0]) : sh;
    endfunction

endpackage

// File: rtl/crc_serial_seq.sv
module crc_serial_seq
    import crc_serial_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      bit_vld_i,
    input  logic      bit_i,
    input  logic      sof_i,
    input  logic      eof_i,
    input  logic      mode_i,
    output step_ctl_t ctl_o,
    output logic      pad_o,
    output logic      gen_o
);

    seq_state_e           state_q, state_n;
    logic [PAD_CNT_W-1:0] cnt_q, cnt_n;
    logic                 gen_q, gen_n;
    logic                 start;

    assign start = sof_i & bit_vld_i;

    always_comb begin
        ctl_o   = '0;
        state_n = state_q;
        cnt_n   = cnt_q;
        gen_n   = gen_q;
        if (start) begin
            ctl_o.clr = 1'b1;
            ctl_o.adv = 1'b1;
            ctl_o.din = bit_i;
            gen_n     = mode_i;
            if (eof_i) begin
                if (mode_i) begin
                    state_n = SQ_PAD;
                    cnt_n   = '0;
                end else begin
                    ctl_o.fin = 1'b1;
                    state_n   = SQ_IDLE;
                end
            end else begin
                state_n = SQ_DATA;
            end
        end else begin
            unique case (state_q)
                SQ_DATA: begin
                    if (bit_vld_i) begin
                        ctl_o.adv = 1'b1;
                        ctl_o.din = bit_i;
                        if (eof_i) begin
                            if (gen_q) begin
                                state_n = SQ_PAD;
                                cnt_n   = '0;
                            end else begin
                                ctl_o.fin = 1'b1;
                                state_n   = SQ_IDLE;
                            end
                        end
                    end
                end
                SQ_PAD: begin
                    ctl_o.adv = 1'b1;
                    ctl_o.din = 1'b0;
                    if (cnt_q == PAD_CNT_W'(CRC_W - 1)) begin
                        ctl_o.fin = 1'b1;
                        state_n   = SQ_IDLE;
                    end else begin
                        cnt_n = cnt_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
        ctl_o.gen = gen_n;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= SQ_IDLE;
            cnt_q   <= '0;
            gen_q   <= 1'b0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            gen_q   <= gen_n;
        end
    end

    assign pad_o = (state_q == SQ_PAD);
    assign gen_o = gen_q;

endmodule

// File: rtl/crc_serial_div.sv
module crc_serial_div
    import crc_serial_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  step_ctl_t ctl_i,
    output rem_t      rem_o,
    output rem_t      rem_next_o
);

    rem_t rem_q;
    rem_t base;

    always_comb begin
        base       = ctl_i.clr ? '0 : rem_q;
        rem_next_o = ctl_i.adv ? div_step(base, ctl_i.din) : rem_q;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) rem_q <= '0;
        else       rem_q <= rem_next_o;
    end

    assign rem_o = rem_q;

endmodule

// File: rtl/crc_serial_flag.sv
module crc_serial_flag
    import crc_serial_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  step_ctl_t ctl_i,
    input  rem_t      rem_next_i,
    output logic      done_o,
    output logic      ok_o
);

    logic done_q, ok_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            done_q <= 1'b0;
            ok_q   <= 1'b0;
        end else begin
            done_q <= ctl_i.fin;
            if (ctl_i.fin)      ok_q <= ctl_i.gen | (rem_next_i == '0);
            else if (ctl_i.clr) ok_q <= 1'b0;
        end
    end

    assign done_o = done_q;
    assign ok_o   = ok_q;

endmodule

// File: rtl/crc_serial_unit.sv
module crc_serial_unit
    import crc_serial_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             bit_vld_i,
    input  logic             bit_i,
    input  logic             sof_i,
    input  logic             eof_i,
    input  logic             mode_i,
    output logic [CRC_W-1:0] rem_o,
    output logic             done_o,
    output logic             ok_o
);

    step_ctl_t ctl_w;
    rem_t      rem_next_w;
    logic      pad_w;
    logic      gen_w;

    crc_serial_seq seq_i (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .bit_vld_i (bit_vld_i),
        .bit_i     (bit_i),
        .sof_i     (sof_i),
        .eof_i     (eof_i),
        .mode_i    (mode_i),
        .ctl_o     (ctl_w),
        .pad_o     (pad_w),
        .gen_o     (gen_w)
    );

    crc_serial_div div_i (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .ctl_i      (ctl_w),
        .rem_o      (rem_o),
        .rem_next_o (rem_next_w)
    );

    crc_serial_flag flag_i (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .ctl_i      (ctl_w),
        .rem_next_i (rem_next_w),
        .done_o     (done_o),
        .ok_o       (ok_o)
    );

endmodule

// File: rtl/crc_serial_chk.sv
module crc_serial_chk
    import crc_serial_pkg::*;
(
    input logic             clk_i,
    input logic             rst_i,
    input logic             bit_vld_i,
    input logic             sof_i,
    input logic             eof_i,
    input logic [CRC_W-1:0] rem_i,
    input logic             done_i,
    input logic             ok_i,
    input logic             pad_i,
    input logic             gen_i
);

    AST_CHECK_VERDICT: assert property (@(posedge clk_i) disable iff (rst_i)
        (done_i && !gen_i) |-> (ok_i == (rem_i == '0)));             // R3

    AST_GEN_OK: assert property (@(posedge clk_i) disable iff (rst_i)
        (done_i && gen_i) |-> ok_i);                                  // R10

    AST_REM_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
        (!bit_vld_i && !pad_i) |=> $stable(rem_i));                   // R4

    AST_OK_STEADY: assert property (@(posedge clk_i) disable iff (rst_i)
        (ok_i != $past(ok_i)) |-> (done_i || $past(sof_i && bit_vld_i))); // R8

    AST_DONE_SOURCE: assert property (@(posedge clk_i) disable iff (rst_i)
        done_i |-> ($past(pad_i) || $past(eof_i && bit_vld_i)));       // R6

endmodule

bind crc_serial_unit crc_serial_chk chk_i (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .bit_vld_i (bit_vld_i),
    .sof_i     (sof_i),
    .eof_i     (eof_i),
    .rem_i     (rem_o),
    .done_i    (done_o),
    .ok_i      (ok_o),
    .pad_i     (pad_w),
    .gen_i     (gen_w)
);

// File: tb/crc_serial_unit_tb_top.sv
module crc_serial_unit_tb_top;

    logic       clk_i = 1'b0;
    logic       rst_i = 1'b1;
    logic       bit_vld_i = 1'b0;
    logic       bit_i = 1'b0;
    logic       sof_i = 1'b0;
    logic       eof_i = 1'b0;
    logic       mode_i = 1'b0;
    logic [4:0] rem_o;
    logic       done_o;
    logic       ok_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [4:0] got_rem;
    logic       got_ok;
    int         got_lat;
    logic       got_done_after;

    crc_serial_unit dut_i (
        .clk_i(clk_i), .rst_i(rst_i), .bit_vld_i(bit_vld_i), .bit_i(bit_i),
        .sof_i(sof_i), .eof_i(eof_i), .mode_i(mode_i),
        .rem_o(rem_o), .done_o(done_o), .ok_o(ok_o)
    );

    always #5 clk_i = ~clk_i;

    always @(posedge clk_i) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog act=%0d exp<150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Polynomial long division by 110101, written on the whole vector.
    function automatic logic [4:0] model_mod(input logic [63:0] v, input int len);
        for (int i = len - 1; i >= 5; i--)
            if (v[i]) v[i -: 6] = v[i -: 6] ^ 6'b110101;
        return v[4:0];
    endfunction

    task automatic idle();
        @(negedge clk_i);
        bit_vld_i = 1'b0; sof_i = 1'b0; eof_i = 1'b0; bit_i = 1'b1;
    endtask

    // Send one frame; gap idle cycles between bits; noise drives valid 1s
    // while waiting for done; flip toggles mode_i after the first bit.
    task automatic run_frame(input logic [63:0] bits, input int len, input logic gen,
                             input int gap, input logic noise, input logic flip);
        for (int j = 0; j < len; j++) begin
            if (j > 0) for (int g = 0; g < gap; g++) idle();
            @(negedge clk_i);
            bit_vld_i = 1'b1;
            bit_i     = bits[len-1-j];
            sof_i     = (j == 0);
            eof_i     = (j == len - 1);
            mode_i    = (j == 0 || !flip) ? gen : !gen;
        end
        got_lat = 0;
        got_rem = 'x;
        got_ok  = 1'bx;
        for (int w = 0; w < 40; w++) begin
            @(negedge clk_i);
            got_lat++;
            bit_vld_i = noise; bit_i = 1'b1; sof_i = 1'b0; eof_i = 1'b0;
            if (done_o) begin
                got_rem = rem_o;
                got_ok  = ok_o;
                break;
            end
        end
        @(negedge clk_i);
        got_done_after = done_o;
        bit_vld_i = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 rem after reset", rem_o, 0);
        check("R1 done after reset", done_o, 0);
        check("R1 ok after reset", ok_o, 0);
    endtask

    task automatic t_gen_worked();
        run_frame(64'b1010001101, 10, 1'b1, 0, 1'b0, 1'b0);
        check("R2 worked FCS", got_rem, 5'b01110);
        check("R10 ok in generate", got_ok, 1);
        check("R6 generate latency", got_lat, 6);
        check("R7 done single cycle", got_done_after, 0);
    endtask

    task automatic t_chk_worked();
        run_frame(64'b101000110101110, 15, 1'b0, 0, 1'b0, 1'b0);
        check("R3 worked frame rem", got_rem, 0);
        check("R3 worked frame ok", got_ok, 1);
        check("R6 check latency", got_lat, 1);
        check("R7 done single cycle chk", got_done_after, 0);
    endtask

    task automatic t_chk_errors();
        logic [63:0] f;
        f = 64'b101000110101110 ^ 64'h10;
        run_frame(f, 15, 1'b0, 0, 1'b0, 1'b0);
        check("R3 single-bit error rem", got_rem, model_mod(f, 15));
        check("R3 single-bit error ok", got_ok, 0);
        f = 64'b101000110101110 ^ 64'b000011110000000;
        run_frame(f, 15, 1'b0, 0, 1'b0, 1'b0);
        check("R3 burst error rem", got_rem, model_mod(f, 15));
        check("R3 burst error ok", got_ok, (model_mod(f, 15) == 0));
    endtask

    task automatic t_gaps_noise_flip();
        logic [63:0] m;
        logic [4:0]  fcs;
        m   = 64'b110010111001;
        fcs = model_mod(m << 5, 17);
        run_frame(m, 12, 1'b1, 2, 1'b1, 1'b1);
        check("R4 gaps do not alter FCS", got_rem, fcs);
        check("R5 R9 mode flip and pad noise ignored", got_ok, 1);
        run_frame((m << 5) | 64'(fcs), 17, 1'b0, 1, 1'b0, 1'b1);
        check("R3 R5 built frame passes", got_ok, 1);
        check("R3 built frame rem", got_rem, 0);
    endtask

    task automatic t_hold_and_clear();
        logic [4:0] r0;
        logic       k0;
        run_frame(64'b101000110101110 ^ 64'h1, 15, 1'b0, 0, 1'b0, 1'b0);
        r0 = rem_o; k0 = ok_o;
        check("R3 lsb error flagged", k0, 0);
        for (int c = 0; c < 3; c++) begin
            @(negedge clk_i);
            bit_vld_i = 1'b1; bit_i = 1'b1; sof_i = 1'b0; eof_i = 1'b0;
        end
        @(negedge clk_i);
        bit_vld_i = 1'b0;
        check("R9 stray bits outside frame", rem_o, r0);
        check("R8 ok holds", ok_o, k0);
        run_frame(64'b1010001101, 10, 1'b1, 0, 1'b0, 1'b0);
        check("R8 ok set at done", ok_o, 1);
        @(negedge clk_i);
        bit_vld_i = 1'b1; sof_i = 1'b1; eof_i = 1'b0; bit_i = 1'b1; mode_i = 1'b0;
        @(negedge clk_i);
        bit_vld_i = 1'b0; sof_i = 1'b0;
        check("R8 ok cleared at start", ok_o, 0);
        check("R5 rem restarts at start", rem_o, 5'b00001);
    endtask

    task automatic t_sweep();
        logic [63:0] m;
        logic [4:0]  fcs;
        for (int k = 1; k <= 6; k++) begin
            m   = 64'((16'h1357 * k) ^ (16'h0f0f >> k));
            fcs = model_mod(m << 5, 21);
            run_frame(m, 16, 1'b1, k % 3, 1'b0, 1'b0);
            check("R2 sweep FCS", got_rem, fcs);
            run_frame((m << 5) | 64'(fcs), 21, 1'b0, 0, 1'b0, 1'b0);
            check("R3 sweep frame ok", got_ok, 1);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        t_reset();
        rst_i = 1'b0;
        @(negedge clk_i);
        t_reset();
        t_gen_worked();
        t_chk_worked();
        t_chk_errors();
        t_gaps_noise_flip();
        t_hold_and_clear();
        t_sweep();
        repeat (2) @(negedge clk_i);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule